// File: doc/BRIEF.md
# Block Compare-and-Swap Merge Unit

This unit is the step engine of a block-level even-odd merge sort. Each operation takes two blocks of four unsigned keys and returns two blocks of four keys, a low block and a high block, each in ascending order. An address sequencer and a key memory outside the unit feed it one block pair per clock. Because the sort works on whole blocks, the sequencer can handle sequences of any length that is a multiple of the block size.

There are two modes. In pre-sort mode the two incoming blocks are raw, and each one is sorted within its own slot. Block A comes out as the low block and block B as the high block. In merge mode both incoming blocks are already ascending. The unit merges them so that the four smallest of the eight keys form the low block and the four largest form the high block. Both modes run on the same eight lanes through three comparator layers. Each layer is followed by a register, so each mode completes in three cycles. Mode and valid travel with the data, so consecutive operations may use different modes.

Top module: `bcs_merge_unit`

## Requirements
- R1: With `in_mode` = 0 (pre-sort), `out_lo` holds the four keys of `in_a` in ascending order and `out_hi` holds the four keys of `in_b` in ascending order.
- R2: With `in_mode` = 1 (merge) and both `in_a` and `in_b` ascending, `out_lo` holds the four smallest of the eight keys in ascending order and `out_hi` holds the four largest in ascending order, so `out_lo` key 3 ≤ `out_hi` key 0.
- R3: The eight output keys are a permutation of the eight input keys: no key is lost or repeated, including when keys are equal.
- R4: A result leaves with `out_vld` high exactly three rising clock edges after the edge that captured its inputs with `in_vld` high.
- R5: A new operation can be accepted on every clock edge, and back-to-back operations come out in order on consecutive cycles.
- R6: `out_mode` equals the `in_mode` value that was captured with the operation being presented.
- R7: While `rst_n` is low, and afterwards until the first operation has passed through, `out_vld` stays low.
- R8: An edge that captures `in_vld` low produces a cycle with `out_vld` low three edges later.
- R9: Keys are compared as unsigned numbers. Key k of a block sits at bits [k*KEY_W +: KEY_W], and key 0 is the smallest key of a sorted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | An operation is presented this cycle |
| in_mode | input | 1 | 0 = pre-sort each block, 1 = merge two sorted blocks |
| in_a | input | 4*KEY_W | First key block, key k at bits [k*KEY_W +: KEY_W] |
| in_b | input | 4*KEY_W | Second key block, same packing |
| out_vld | output | 1 | Result present |
| out_mode | output | 1 | Mode of the presented result |
| out_lo | output | 4*KEY_W | Low result block, ascending |
| out_hi | output | 4*KEY_W | High result block, ascending |

## Verification
Every result is due three cycles after it was driven, in both modes, because the two comparator networks share the same three register stages. The driver stamps each expected pair of blocks with its drive cycle, and the monitor requires that `out_vld` rises exactly when the oldest stamp is three cycles old. A result that comes early, a result that comes late, and a valid cycle with nothing outstanding are all counted as miscompares. Driving happens on falling edges and outputs are sampled on falling edges, so a sample never falls on the edge where the result is registered.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int unsigned BLK   = 4;
  localparam int unsigned LANES = 2 * BLK;
  localparam int unsigned NSTG  = 3;

  typedef enum logic {
    MODE_PRESORT = 1'b0,
    MODE_MERGE   = 1'b1
  } bcs_mode_e;

  // Partner lane of `lane` in comparator layer `stg`; returns `lane` when idle.
  // Lanes 0..3 carry block A, lanes 4..7 block B.
  function automatic int bcs_partner(input bit merge, input int stg, input int lane);
    int p;
    p = lane;
    if (!merge) begin
      case (stg)
        0: p = lane ^ 1;
        1: p = lane ^ 2;
        2: begin
          if ((lane % 4) == 1)      p = lane + 1;
          else if ((lane % 4) == 2) p = lane - 1;
        end
        default: p = lane;
      endcase
    end else begin
      case (stg)
        0: p = lane ^ 4;
        1: begin
          if (lane == 2 || lane == 3)      p = lane + 2;
          else if (lane == 4 || lane == 5) p = lane - 2;
        end
        2: begin
          if (lane == 1 || lane == 3 || lane == 5)      p = lane + 1;
          else if (lane == 2 || lane == 4 || lane == 6) p = lane - 1;
        end
        default: p = lane;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/bcs_lane_cas.sv
module bcs_lane_cas #(
  parameter int KEY_W    = 16,
  parameter int LANE     = 0,
  parameter int PEER_PRE = 0,
  parameter int PEER_MRG = 0
) (
  input  logic             merge_i,
  input  logic [KEY_W-1:0] own_i,
  input  logic [KEY_W-1:0] pre_peer_i,
  input  logic [KEY_W-1:0] mrg_peer_i,
  output logic [KEY_W-1:0] key_o
);

  function automatic logic [KEY_W-1:0] cas_pick(
    input logic [KEY_W-1:0] own,
    input logic [KEY_W-1:0] peer,
    input int               self_lane,
    input int               peer_lane
  );
    if (peer_lane == self_lane)     return own;
    else if (self_lane < peer_lane) return (peer < own) ? peer : own;
    else                            return (peer > own) ? peer : own;
  endfunction

  logic [KEY_W-1:0] pre_res;
  logic [KEY_W-1:0] mrg_res;

  always_comb begin
    pre_res = cas_pick(own_i, pre_peer_i, LANE, PEER_PRE);
    mrg_res = cas_pick(own_i, mrg_peer_i, LANE, PEER_MRG);
    key_o   = merge_i ? mrg_res : pre_res;
  end

endmodule

// File: rtl/bcs_stage.sv
module bcs_stage
  import bcs_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int STG   = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_vld,
  input  bcs_mode_e                   in_mode,
  input  logic [LANES-1:0][KEY_W-1:0] in_keys,
  output logic                        out_vld,
  output bcs_mode_e                   out_mode,
  output logic [LANES-1:0][KEY_W-1:0] out_keys
);

  localparam int SUM_W = KEY_W + $clog2(LANES) + 1;

  logic [LANES-1:0][KEY_W-1:0] cas_keys;
  logic [LANES-1:0][KEY_W-1:0] keys_q;
  bcs_mode_e                   mode_q;
  logic                        vld_q;
  logic                        nxt_vld;
  logic                        data_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int PP = bcs_partner(1'b0, STG, g);
    localparam int PM = bcs_partner(1'b1, STG, g);
    bcs_lane_cas #(
      .KEY_W   (KEY_W),
      .LANE    (g),
      .PEER_PRE(PP),
      .PEER_MRG(PM)
    ) u_cas (
      .merge_i   (in_mode == MODE_MERGE),
      .own_i     (in_keys[g]),
      .pre_peer_i(in_keys[PP]),
      .mrg_peer_i(in_keys[PM]),
      .key_o     (cas_keys[g])
    );
  end

  always_comb begin
    nxt_vld = in_vld;
    data_en = in_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= nxt_vld;
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      keys_q <= cas_keys;
      mode_q <= in_mode;
    end
  end

  assign out_vld  = vld_q;
  assign out_mode = mode_q;
  assign out_keys = keys_q;

  logic [SUM_W-1:0] in_sum;
  logic [SUM_W-1:0] out_sum;

  always_comb begin
    in_sum  = '0;
    out_sum = '0;
    for (int i = 0; i < LANES; i++) begin
      in_sum  = in_sum  + SUM_W'(in_keys[i]);
      out_sum = out_sum + SUM_W'(keys_q[i]);
    end
  end

  // R4
  stage_vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(in_vld));

  // R8
  stage_vld_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_vld)) |-> vld_q);

  // R6
  stage_mode_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (mode_q == $past(in_mode)));

  // R3
  stage_key_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (out_sum == $past(in_sum)));

endmodule

// File: rtl/bcs_merge_unit.sv
module bcs_merge_unit
  import bcs_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_mode,
  input  logic [BLK*KEY_W-1:0] in_a,
  input  logic [BLK*KEY_W-1:0] in_b,
  output logic               out_vld,
  output logic               out_mode,
  output logic [BLK*KEY_W-1:0] out_lo,
  output logic [BLK*KEY_W-1:0] out_hi
);

  logic rst_n_sync;

  logic [NSTG:0]                        vld_c;
  bcs_mode_e                            mode_c [NSTG+1];
  logic [NSTG:0][LANES-1:0][KEY_W-1:0]  keys_c;

  bcs_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n_i(rst_n),
    .rst_n_o(rst_n_sync)
  );

  assign vld_c[0]  = in_vld;
  assign mode_c[0] = bcs_mode_e'(in_mode);

  for (genvar k = 0; k < BLK; k++) begin : g_pack
    assign keys_c[0][k]       = in_a[k*KEY_W +: KEY_W];
    assign keys_c[0][BLK + k] = in_b[k*KEY_W +: KEY_W];
    assign out_lo[k*KEY_W +: KEY_W] = keys_c[NSTG][k];
    assign out_hi[k*KEY_W +: KEY_W] = keys_c[NSTG][BLK + k];
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    bcs_stage #(
      .KEY_W(KEY_W),
      .STG  (s)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .in_vld  (vld_c[s]),
      .in_mode (mode_c[s]),
      .in_keys (keys_c[s]),
      .out_vld (vld_c[s+1]),
      .out_mode(mode_c[s+1]),
      .out_keys(keys_c[s+1])
    );
  end

  assign out_vld  = vld_c[NSTG];
  assign out_mode = logic'(mode_c[NSTG]);

  logic lo_asc;
  logic hi_asc;

  always_comb begin
    lo_asc = 1'b1;
    hi_asc = 1'b1;
    for (int i = 0; i < BLK - 1; i++) begin
      if (keys_c[NSTG][i] > keys_c[NSTG][i+1])             lo_asc = 1'b0;
      if (keys_c[NSTG][BLK+i] > keys_c[NSTG][BLK+i+1])     hi_asc = 1'b0;
    end
  end

  // R7
  out_vld_reset_chk: assert property (@(posedge clk)
    !rst_n_sync |=> !out_vld);

  // R1
  presort_order_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (out_vld && out_mode == 1'b0) |-> (lo_asc && hi_asc));

  // R2
  merge_order_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (out_vld && out_mode == 1'b1) |-> (lo_asc && hi_asc));

  // R2
  merge_split_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (out_vld && out_mode == 1'b1) |-> (keys_c[NSTG][BLK-1] <= keys_c[NSTG][BLK]));

endmodule

// File: tb/test_bcs_merge_unit.sv
module test_bcs_merge_unit;

  localparam int CLK_PERIOD = 10;
  localparam int KW   = 8;
  localparam int NB   = 4;
  localparam int BW   = NB * KW;
  localparam int LAT  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_vld;
  logic          in_mode;
  logic [BW-1:0] in_a;
  logic [BW-1:0] in_b;
  logic          out_vld;
  logic          out_mode;
  logic [BW-1:0] out_lo;
  logic [BW-1:0] out_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcs_merge_unit #(.KEY_W(KW)) i_bcs_merge_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_mode (in_mode),
    .in_a    (in_a),
    .in_b    (in_b),
    .out_vld (out_vld),
    .out_mode(out_mode),
    .out_lo  (out_lo),
    .out_hi  (out_hi)
  );

  typedef struct {
    logic [BW-1:0] lo;
    logic [BW-1:0] hi;
    logic          mode;
    int            cyc;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  int   cyc_cnt  = 0;
  bit   done     = 1'b0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic void sort_n(inout int v[8], input int n);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n - 1 - i; j++)
        if (v[j] > v[j+1]) begin
          int t = v[j]; v[j] = v[j+1]; v[j+1] = t;
        end
  endfunction

  function automatic logic [BW-1:0] pack4(input int v[8], input int base);
    logic [BW-1:0] r;
    for (int k = 0; k < NB; k++) r[k*KW +: KW] = KW'(v[base + k]);
    return r;
  endfunction

  // Expected result built from R1 / R2 / R9 (unsigned, key k at bits k*KW).
  task automatic drive_op(input logic mode, input logic [BW-1:0] a, input logic [BW-1:0] b);
    int   va[8];
    int   vb[8];
    int   vall[8];
    exp_t e;
    for (int k = 0; k < NB; k++) begin
      va[k] = int'(a[k*KW +: KW]);
      vb[k] = int'(b[k*KW +: KW]);
      vall[k] = va[k];
      vall[NB + k] = vb[k];
    end
    if (mode == 1'b0) begin
      sort_n(va, NB);
      sort_n(vb, NB);
      e.lo = pack4(va, 0);
      e.hi = pack4(vb, 0);
    end else begin
      sort_n(vall, 2*NB);
      e.lo = pack4(vall, 0);
      e.hi = pack4(vall, NB);
    end
    e.mode = mode;
    e.cyc  = cyc_cnt;
    sb_q.push_back(e);
    in_vld  = 1'b1;
    in_mode = mode;
    in_a    = a;
    in_b    = b;
    @(negedge clk);
    in_vld  = 1'b0;
  endtask

  task automatic idle(input int n);
    in_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [BW-1:0] rand_blk(input int range, input bit sorted);
    int v[8];
    for (int k = 0; k < NB; k++) v[k] = int'($urandom_range(range - 1, 0));
    if (sorted) sort_n(v, NB);
    return pack4(v, 0);
  endfunction

  function automatic logic [BW-1:0] blk4(input int k0, input int k1, input int k2, input int k3);
    return {KW'(k3), KW'(k2), KW'(k1), KW'(k0)};
  endfunction

  // Monitor: R4 timing, R1/R2/R3 contents, R6 mode, R8 no spurious output.
  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (out_vld) begin
        if (sb_q.size() == 0) begin
          n_checks++;
          n_fails++;
          $display("FAIL R8: out_vld=1 with nothing outstanding, expected 0");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          n_checks++;
          if (cyc_cnt != e.cyc + LAT) begin
            n_fails++;
            $display("FAIL R4: result at cycle %0d, expected cycle %0d", cyc_cnt, e.cyc + LAT);
          end
          if (out_lo !== e.lo || out_hi !== e.hi) begin
            n_fails++;
            $display("FAIL %s/R3: lo=%h hi=%h, expected lo=%h hi=%h",
                     e.mode ? "R2" : "R1", out_lo, out_hi, e.lo, e.hi);
          end
          if (out_mode !== e.mode) begin
            n_fails++;
            $display("FAIL R6: out_mode=%0b, expected %0b", out_mode, e.mode);
          end
        end
      end else if (sb_q.size() != 0 && cyc_cnt >= sb_q[0].cyc + LAT) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        n_fails++;
        $display("FAIL R4: out_vld=0 at cycle %0d, expected 1 (driven cycle %0d)", cyc_cnt, e.cyc);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    n_checks++;
    n_fails++;
    $display("FAIL R4: watchdog expired with %0d results pending, expected 0", sb_q.size());
    finish_run();
  end

  initial begin
    rst_n   = 1'b0;
    in_vld  = 1'b0;
    in_mode = 1'b0;
    in_a    = '0;
    in_b    = '0;
    repeat (3) @(negedge clk);
    // R7: no output during reset
    n_checks++;
    if (out_vld !== 1'b0) begin
      n_fails++;
      $display("FAIL R7: out_vld=%b during reset, expected 0", out_vld);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R7: still idle after release
    n_checks++;
    if (out_vld !== 1'b0) begin
      n_fails++;
      $display("FAIL R7: out_vld=%b after reset, expected 0", out_vld);
    end

    // R1 directed: reversed block, all-equal block
    drive_op(1'b0, blk4(4, 3, 2, 1), blk4(5, 5, 5, 5));
    idle(4);
    // R2 directed: interleaved sorted blocks
    drive_op(1'b1, blk4(1, 3, 5, 7), blk4(2, 4, 6, 8));
    // R2 directed: every A key above every B key
    drive_op(1'b1, blk4(200, 210, 220, 230), blk4(10, 20, 30, 40));
    // R3 directed: all keys equal across both blocks
    drive_op(1'b1, blk4(9, 9, 9, 9), blk4(9, 9, 9, 9));
    // R9 directed: keys with the top bit set must sort above small keys
    drive_op(1'b0, blk4(255, 1, 128, 127), blk4(0, 254, 129, 2));
    drive_op(1'b1, blk4(1, 127, 128, 255), blk4(0, 2, 129, 254));
    idle(5);

    // R5: back-to-back pre-sort, then merge, then alternating modes
    for (int i = 0; i < 150; i++) drive_op(1'b0, rand_blk(256, 1'b0), rand_blk(256, 1'b0));
    for (int i = 0; i < 150; i++) drive_op(1'b1, rand_blk(256, 1'b1), rand_blk(256, 1'b1));
    for (int i = 0; i < 200; i++) begin
      logic m = logic'(i % 2);
      drive_op(m, rand_blk(256, m), rand_blk(256, m));
    end
    // R3: narrow key range gives many duplicates
    for (int i = 0; i < 200; i++) begin
      logic m = logic'($urandom_range(1, 0));
      drive_op(m, rand_blk(4, m), rand_blk(4, m));
    end
    // R8: random idle gaps between operations
    for (int i = 0; i < 200; i++) begin
      logic m = logic'($urandom_range(1, 0));
      drive_op(m, rand_blk(256, m), rand_blk(256, m));
      if ($urandom_range(2, 0) == 0) idle(int'($urandom_range(3, 1)));
    end

    idle(LAT + 4);
    if (sb_q.size() != 0) begin
      n_checks++;
      n_fails++;
      $display("FAIL R4: %0d results never arrived, expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule